// File: doc/BRIEF.md
# Low-Toggle Weighted Pattern Generator

This block produces pseudorandom stimulus for scan chains while limiting how often the scan inputs change from one shift cycle to the next. A maximal-length shift register advances every clock and feeds a bank of per-bit hold registers. A hold register either copies its new pseudorandom bit or keeps the value it already has. A fixed XOR network then folds three hold registers into each scan-chain input. When fewer hold registers are refreshed, fewer chain inputs change, so shift power falls.

Two mechanisms decide which hold registers are refreshed. The first is a per-pattern enable mask. A shadow register fills one bit per cycle from a weighted random source, and `pattern_start` copies it into the mask. The second is a global run/freeze flag. While the flag is in freeze, every hold register keeps its value. The flag flips at random moments, with a weight taken from one of two programmable codes: one applies while running and the other while frozen. The switching code, the run-exit code and the freeze-exit code are written through a small 4-bit configuration port. A switching code of zero turns the low-power function off.

Top module: `lowtog_prpg`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `scan_out` is all zeros. Reset leaves the switching code, run-exit code and freeze-exit code at 0, the flag in run, and the mask at 0.
- R2: The source register has N bits. It resets to SEED (16'hACE1 by default). Each clock it becomes `{q[N-2:0], ^(q & TAPS)}`, with TAPS 16'hB400 by default, and it is never zero.
- R3: Scan output j is the XOR of hold registers j, (j+5) mod N and (j+11) mod N. The value appears on `scan_out` one clock after it is in the hold registers.
- R4: While the switching code is 0000, every hold register loads its source bit on every clock, whatever the flag and the mask are.
- R5: When the switching code is nonzero, a hold register whose mask bit is 0 keeps its value.
- R6: Each cycle, a weighted bit w(code, base) is shifted into the shadow register at bit 0, with base 0 and the switching code as the code. w(code, b) is the OR over k of code[k] AND term k. With p the source register, term 0 = p[b], term 1 = p[b+1]&p[b+2], term 2 = p[b+3]&p[b+4]&p[b+5], and term 3 = p[b+6]&...&p[b+9], all indices taken mod N.
- R7: When the switching code is nonzero and the flag is in freeze, no hold register changes.
- R8: Outside a pattern start, the flag flips whenever w(code, 8) is 1. The code is the run-exit code while the flag is in run and the freeze-exit code while it is in freeze.
- R9: `pattern_start` copies the shadow register, as it was before this clock's shift, into the mask and puts the flag in run.
- R10: A clock with `cfg_we` high writes `cfg_data` to the switching code (`cfg_sel` 0), the run-exit code (1) or the freeze-exit code (2). The new value takes effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pattern_start | input | 1 | Pattern boundary: reload the mask and put the flag in run |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Selects the code to write: 0 switching, 1 run-exit, 2 freeze-exit |
| cfg_data | input | 4 | Code value to write |
| scan_out | output | S | Registered scan-chain inputs |

## Verification
On every cycle the assertions check four things: the source register never reaches zero, hold registers follow the source while the low-power function is off, nothing moves during a freeze, and masked-off bits keep their value. They also check that a pattern start always leaves the flag in run. The weighting of the random sources, the XOR mapping, and the timing of flag flips under each exit code can only be shown by the bench. It runs a cycle-accurate model built from the requirements and compares the model with `scan_out` on every clock. It also counts transitions per chain, to show full activity with the low-power function off and fully quiet chains when the mask is sparse.

// File: rtl/lowtog_pkg.sv
package lowtog_pkg;
  typedef enum logic [1:0] {
    CFG_SWITCH = 2'd0,
    CFG_RUNEXIT = 2'd1,
    CFG_FRZEXIT = 2'd2
  } cfg_sel_e;

  localparam int CODE_W = 4;
endpackage

// File: rtl/lowtog_lfsr.sv
module lowtog_lfsr #(
  parameter int N = 16,
  parameter logic [N-1:0] TAPS = 16'hB400,
  parameter logic [N-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [N-1:0] q
);
  logic fb;

  always_comb fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[N-2:0], fb};
  end
endmodule

// File: rtl/lowtog_weight.sv
module lowtog_weight #(
  parameter int N = 16,
  parameter int BASE = 0
) (
  input  logic [3:0]   code,
  input  logic [N-1:0] prpg,
  output logic         bit_o
);
  logic [3:0] term;

  always_comb begin
    term[0] = prpg[(BASE) % N];
    term[1] = prpg[(BASE + 1) % N] & prpg[(BASE + 2) % N];
    term[2] = prpg[(BASE + 3) % N] & prpg[(BASE + 4) % N] & prpg[(BASE + 5) % N];
    term[3] = prpg[(BASE + 6) % N] & prpg[(BASE + 7) % N] &
              prpg[(BASE + 8) % N] & prpg[(BASE + 9) % N];
    bit_o   = |(code & term);
  end
endmodule

// File: rtl/lowtog_hold_bank.sv
module lowtog_hold_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= 1'b0;
      else if (en[i]) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/lowtog_phase_shift.sv
module lowtog_phase_shift #(
  parameter int N = 16,
  parameter int S = 8,
  parameter int OFF_A = 5,
  parameter int OFF_B = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] latch,
  output logic [S-1:0] scan
);
  for (genvar j = 0; j < S; j++) begin : g_chain
    localparam int IA = (j + OFF_A) % N;
    localparam int IB = (j + OFF_B) % N;
    always_ff @(posedge clk) begin
      if (rst) scan[j] <= 1'b0;
      else     scan[j] <= latch[j] ^ latch[IA] ^ latch[IB];
    end
  end
endmodule

// File: rtl/lowtog_prpg.sv
module lowtog_prpg
  import lowtog_pkg::*;
#(
  parameter int N = 16,
  parameter int S = 8,
  parameter logic [N-1:0] TAPS = 16'hB400,
  parameter logic [N-1:0] SEED = 16'hACE1,
  parameter int OFF_A = 5,
  parameter int OFF_B = 11,
  parameter int T_BASE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pattern_start,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [3:0]       cfg_data,
  output logic [S-1:0]     scan_out
);
  logic [CODE_W-1:0] switch_q, runexit_q, frzexit_q;
  logic [N-1:0]      lfsr_q, shadow_q, ctrl_q, latch_q, en;
  logic              tff_q, lp_off, w_mask, w_flip;
  logic [CODE_W-1:0] flip_code;

  lowtog_lfsr #(.N(N), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .q(lfsr_q)
  );

  always_comb begin
    lp_off    = (switch_q == '0);
    flip_code = tff_q ? runexit_q : frzexit_q;
    en        = lp_off ? '1 : (ctrl_q & {N{tff_q}});
  end

  lowtog_weight #(.N(N), .BASE(0)) u_wmask (
    .code(switch_q), .prpg(lfsr_q), .bit_o(w_mask)
  );

  lowtog_weight #(.N(N), .BASE(T_BASE)) u_wflip (
    .code(flip_code), .prpg(lfsr_q), .bit_o(w_flip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      switch_q  <= '0;
      runexit_q <= '0;
      frzexit_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_SWITCH:  switch_q  <= cfg_data;
        CFG_RUNEXIT: runexit_q <= cfg_data;
        CFG_FRZEXIT: frzexit_q <= cfg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      ctrl_q   <= '0;
      tff_q    <= 1'b1;
    end else begin
      shadow_q <= {shadow_q[N-2:0], w_mask};
      if (pattern_start) begin
        ctrl_q <= shadow_q;
        tff_q  <= 1'b1;
      end else if (w_flip) begin
        tff_q  <= ~tff_q;
      end
    end
  end

  lowtog_hold_bank #(.N(N)) u_hold (
    .clk(clk), .rst(rst), .en(en), .d(lfsr_q), .q(latch_q)
  );

  lowtog_phase_shift #(.N(N), .S(S), .OFF_A(OFF_A), .OFF_B(OFF_B)) u_ps (
    .clk(clk), .rst(rst), .latch(latch_q), .scan(scan_out)
  );
endmodule

// File: rtl/lowtog_prpg_chk.sv
module lowtog_prpg_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         pattern_start,
  input logic [3:0]   switch_q,
  input logic         tff_q,
  input logic [N-1:0] ctrl_q,
  input logic [N-1:0] lfsr_q,
  input logic [N-1:0] latch_q
);
  AST_SRC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0); // R2

  AST_LPOFF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (switch_q == 4'd0) |=> (latch_q == $past(lfsr_q))); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (switch_q != 4'd0) |=> (((latch_q ^ $past(latch_q)) & ~$past(ctrl_q)) == '0)); // R5

  AST_FREEZE_STILL: assert property (@(posedge clk) disable iff (rst)
    ((switch_q != 4'd0) && !tff_q) |=> $stable(latch_q)); // R7

  AST_START_RUN: assert property (@(posedge clk) disable iff (rst)
    pattern_start |=> tff_q); // R9
endmodule

bind lowtog_prpg lowtog_prpg_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .pattern_start(pattern_start), .switch_q(switch_q),
  .tff_q(tff_q), .ctrl_q(ctrl_q), .lfsr_q(lfsr_q), .latch_q(latch_q)
);

// File: tb/lowtog_prpg_tb.sv
`timescale 1ns/1ps
module lowtog_prpg_tb;
  localparam int N = 16;
  localparam int S = 8;
  localparam logic [N-1:0] TAPS = 16'hB400;
  localparam logic [N-1:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pattern_start = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [3:0] cfg_data = 4'd0;
  logic [S-1:0] scan_out;

  int n_chk_m = 0, n_fail_m = 0, n_chk = 0, n_fail = 0;
  int tcnt [S];
  bit counting = 1'b0;
  bit done = 1'b0;
  logic [S-1:0] prev_scan;
  logic [S-1:0] expq [$];

  // reference model state (from the requirements)
  logic [N-1:0] m_lfsr, m_sh, m_ctrl, m_lat;
  logic m_tff;
  logic [3:0] m_sw, m_tg, m_hd;

  always #4 clk = ~clk;

  lowtog_prpg u_dut (
    .clk(clk), .rst(rst), .pattern_start(pattern_start), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .scan_out(scan_out)
  );

  function automatic logic wfun(input logic [3:0] code, input logic [N-1:0] p, input int b);
    logic [3:0] t;
    t[0] = p[b % N];
    t[1] = p[(b+1) % N] & p[(b+2) % N];
    t[2] = p[(b+3) % N] & p[(b+4) % N] & p[(b+5) % N];
    t[3] = p[(b+6) % N] & p[(b+7) % N] & p[(b+8) % N] & p[(b+9) % N];
    return |(code & t);
  endfunction

  function automatic logic [S-1:0] phase(input logic [N-1:0] l);
    logic [S-1:0] o;
    for (int j = 0; j < S; j++) o[j] = l[j] ^ l[(j+5) % N] ^ l[(j+11) % N];
    return o;
  endfunction

  // driver side: model steps at each edge and pushes the expected output
  always @(posedge clk) begin
    logic wv, wt;
    logic [N-1:0] en, nl;
    if (rst) begin
      m_lfsr = SEED; m_sh = '0; m_ctrl = '0; m_tff = 1'b1; m_lat = '0;
      m_sw = '0; m_tg = '0; m_hd = '0;
      expq.delete();
    end else begin
      expq.push_back(phase(m_lat));
      wv = wfun(m_sw, m_lfsr, 0);
      wt = wfun(m_tff ? m_tg : m_hd, m_lfsr, 8);
      en = (m_sw == 4'd0) ? '1 : (m_tff ? m_ctrl : '0);
      nl = (m_lat & ~en) | (m_lfsr & en);
      if (pattern_start) begin m_ctrl = m_sh; m_tff = 1'b1; end
      else if (wt) m_tff = ~m_tff;
      m_sh = {m_sh[N-2:0], wv};
      m_lfsr = {m_lfsr[N-2:0], ^(m_lfsr & TAPS)};
      m_lat = nl;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_sw = cfg_data;
          2'd1: m_tg = cfg_data;
          2'd2: m_hd = cfg_data;
          default: ;
        endcase
      end
    end
  end

  // monitor: pops expected values and compares away from the edge
  always @(negedge clk) begin
    #1;
    if (!rst && expq.size() > 0) begin
      logic [S-1:0] e;
      e = expq.pop_front();
      n_chk_m++;
      if (scan_out !== e) begin
        n_fail_m++;
        $display("FAIL R2 R3 R6 R8 R9 R10 model compare: scan_out=%h expected=%h at %0t",
                 scan_out, e, $time);
      end
      if (counting)
        for (int j = 0; j < S; j++) if (scan_out[j] != prev_scan[j]) tcnt[j]++;
      prev_scan = scan_out;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_pat();
    @(negedge clk);
    pattern_start = 1'b1;
    @(negedge clk);
    pattern_start = 1'b0;
  endtask

  task automatic count_window(input int n);
    @(negedge clk);
    for (int j = 0; j < S; j++) tcnt[j] = 0;
    counting = 1'b1;
    cyc(n);
    #2;
    counting = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***",
               n_chk + n_chk_m, n_fail + n_fail_m);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [S-1:0] s1;
    int quiet;
    cyc(3);
    #2;
    check("R1 scan during reset", scan_out, '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    check("R1 scan after reset", scan_out, '0);

    // R4: low-power off by default, every chain should be busy
    count_window(200);
    for (int j = 0; j < S; j++) check("R4 chain active with code 0000", (tcnt[j] >= 40), 1);

    // R5 R6 R10: sparse mask, flag kept in run
    cfg(2'd0, 4'b1000);
    cfg(2'd1, 4'b0000);
    cfg(2'd2, 4'b0000);
    cyc(N + 4);
    start_pat();
    count_window(100);
    quiet = 0;
    for (int j = 0; j < S; j++) begin
      if (!m_ctrl[j] && !m_ctrl[(j+5) % N] && !m_ctrl[(j+11) % N]) begin
        quiet++;
        check("R5 chain with all sources masked stays constant", tcnt[j], 0);
      end
    end
    check("R6 weight 1/16 leaves some chain fully masked", (quiet > 0), 1);

    // R7 R8: enter freeze and never leave it
    cfg(2'd0, 4'b0011);
    cfg(2'd1, 4'b0001);
    cyc(N + 4);
    start_pat();
    cyc(60);
    check("R8 flag reached freeze", m_tff, 0);
    #2;
    s1 = scan_out;
    count_window(30);
    check("R7 freeze keeps scan constant", scan_out, s1);

    // R9: start returns to run; R8 alternation with both exit codes set
    cfg(2'd2, 4'b0001);
    start_pat();
    check("R9 flag in run after start", m_tff, 1);
    cyc(150);
    cfg(2'd1, 4'b1111);
    cfg(2'd2, 4'b0100);
    cyc(150);

    // R10: write back to 0000 restores full activity from the next clock
    cfg(2'd0, 4'b0000);
    count_window(120);
    for (int j = 0; j < S; j++) check("R10 code 0000 rewrite restores activity", (tcnt[j] >= 20), 1);

    cyc(4);
    finish_run();
  end
endmodule